// File: doc/BRIEF.md
# Video Processor Control Port Decoder

This block sits behind the 16-bit control port of a tile-based video processor. Each word written to the port is either a complete register write or one half of a two-word command that sets the access address and the access code. The block keeps the address register, the six-bit access code, the flag that says a second command word is expected, and the processor's configuration register file.

After the second word of a command it decides whether a DMA is wanted. If so, it selects one of three kinds from a field of register 23: a fill, armed now and launched by the next data-port write; a copy inside video RAM; or a transfer from system memory into the video memories. It raises a one-cycle start pulse for the chosen kind and presents the transfer length decoded from two registers. It does not contain the DMA engines. Those engines report back with a done strobe. Control words that arrive while a DMA is running are parked and then applied when the DMA finishes. Data-port and status-port strobes also act on the decoder's state: they clear the pending flag, and data accesses step the address.

Top module: `ctrl_port_decoder`

## Requirements
- R1: After reset, the address, the access code, the pending flag, every register, the fill arm and the DMA-active flag are all zero.
- R2: When no second word is pending, a control word with bits 15:14 equal to 2'b10 is a register write. The index is taken from bits 12:8 and the value from bits 7:0. Indices 24 to 31 leave every register unchanged. Reading index 24 to 31 on the register read port returns zero.
- R3: Every first word loads address bits 13:0 from word bits 13:0 and code bits 1:0 from word bits 15:14. Address bits 15:14 are taken from the latched high bits. A first word that is not a register write sets the pending flag.
- R4: A second word clears the pending flag. It loads address bits 15:14 from word bits 1:0 and keeps them latched for later first words. It loads code bits 5:2 from word bits 7:4.
- R5: A second word requests a DMA only when the new code bit 5 and register 1 bit 4 are both set. With register 23 bits 7:6 equal to 2 and code bits 3:0 equal to 4'h1, the fill is armed. The next data-port write then raises fill_start for exactly one cycle, on the clock edge that takes the write.
- R6: With register 23 bits 7:6 equal to 3, a requested DMA raises copy_start for one cycle, on the edge that takes the second word, but only if code bits 4:0 equal 5'h10. Any other code starts nothing.
- R7: With register 23 bits 7 equal to 0, a requested DMA raises xfer_start for one cycle, on the edge that takes the second word.
- R8: dma_len equals {register 20, register 19}. A value of zero reads as 65536.
- R9: A write to register index 11 to 23 is dropped unless register 1 bit 2 is already set before that write.
- R10: A status read, a data-port read and a data-port write each clear the pending flag.
- R11: Every data-port read or write adds register 15 to the address, modulo 65536.
- R12: dma_active rises with any start pulse and falls on the clock edge that samples dma_done. Control words that arrive while dma_active is high change nothing, and the latest one is kept. On the dma_done edge the kept word is applied as a normal control write. The protocol never strobes more than one of ctl_wr, dat_wr, dat_rd and stat_rd in one cycle. If it did, a control write would win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_data | input | 16 | Control-port write data |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe |
| stat_rd | input | 1 | Status-port read strobe |
| dma_done | input | 1 | Running DMA has finished |
| rd_idx | input | 5 | Register read index |
| rd_val | output | 8 | Register value at rd_idx, zero above the file |
| addr | output | 16 | Access address register |
| code | output | 6 | Access code register |
| pending | output | 1 | Second command word expected |
| fill_start | output | 1 | Fill DMA start pulse |
| copy_start | output | 1 | Video-RAM copy start pulse |
| xfer_start | output | 1 | Memory-to-video transfer start pulse |
| dma_len | output | 17 | Decoded DMA length |
| dma_active | output | 1 | A DMA is running and control writes are parked |

## Verification
The bench builds the decoder with its default 24-entry register file and the lockout boundary at index 11. This means the whole index range 0 to 31 is exercised: unlocked registers, locked registers, and indices past the file. Register 15 is set to several step sizes, up to 255, so the address is driven through its 16-bit wrap. A per-cycle reference model follows directed sequences and then a long random mix of control words, data strobes, status reads and done strobes. This mix reaches parked and replayed control words, a zero length reading as 65536, and DMA requests that are refused because of the code or because of register 1.

// File: rtl/ctrl_port_decoder.sv
module ctrl_port_decoder #(
  parameter int NREGS     = 24,
  parameter int LOCK_FROM = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [15:0] ctl_data,
  input  logic        dat_wr,
  input  logic        dat_rd,
  input  logic        stat_rd,
  input  logic        dma_done,
  input  logic [4:0]  rd_idx,
  output logic [7:0]  rd_val,
  output logic [15:0] addr,
  output logic [5:0]  code,
  output logic        pending,
  output logic        fill_start,
  output logic        copy_start,
  output logic        xfer_start,
  output logic [16:0] dma_len,
  output logic        dma_active
);

  localparam int LW = 17;

  logic [7:0]  regs_q [NREGS];
  logic [15:0] addr_q;
  logic [5:0]  code_q;
  logic [1:0]  hi_q;
  logic        pend_q, arm_q, act_q, hold_vld_q;
  logic [15:0] hold_q;

  logic        apply, is_regw, wr_ok, dma_req, dacc, arm_go, copy_go, xfer_go, fill_go;
  logic [15:0] word;
  logic [4:0]  widx;
  logic [5:0]  code2;
  logic [1:0]  kind;

  assign apply   = act_q ? (dma_done && (hold_vld_q || ctl_wr)) : ctl_wr;
  assign word    = (act_q && hold_vld_q) ? hold_q : ctl_data;
  assign is_regw = !pend_q && (word[15:14] == 2'b10);
  assign widx    = word[12:8];
  assign wr_ok   = is_regw && (int'(widx) < NREGS) &&
                   ((int'(widx) < LOCK_FROM) || regs_q[1][2]);
  assign code2   = {word[7:4], code_q[1:0]};
  assign kind    = regs_q[23][7:6];
  assign dma_req = apply && pend_q && code2[5] && regs_q[1][4];
  assign arm_go  = dma_req && (kind == 2'd2) && (code2[3:0] == 4'h1);
  assign copy_go = dma_req && (kind == 2'd3) && (code2[4:0] == 5'h10);
  assign xfer_go = dma_req && !kind[1];
  assign dacc    = dat_wr || dat_rd;
  assign fill_go = !apply && dat_wr && arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
      addr_q <= '0; code_q <= '0; hi_q <= '0; pend_q <= 1'b0; arm_q <= 1'b0;
    end else if (apply) begin
      if (!pend_q) begin
        addr_q      <= {hi_q, word[13:0]};
        code_q[1:0] <= word[15:14];
        pend_q      <= !is_regw;
        if (wr_ok) regs_q[widx] <= word[7:0];
      end else begin
        pend_q        <= 1'b0;
        hi_q          <= word[1:0];
        addr_q[15:14] <= word[1:0];
        code_q[5:2]   <= word[7:4];
        if (arm_go) arm_q <= 1'b1;
      end
    end else begin
      if (dacc) begin
        pend_q <= 1'b0;
        addr_q <= addr_q + {8'b0, regs_q[15]};
        if (dat_wr) arm_q <= 1'b0;
      end
      if (stat_rd) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; hold_vld_q <= 1'b0; hold_q <= '0;
      fill_start <= 1'b0; copy_start <= 1'b0; xfer_start <= 1'b0;
    end else begin
      fill_start <= fill_go;
      copy_start <= copy_go;
      xfer_start <= xfer_go;
      if (act_q && dma_done) begin
        act_q      <= 1'b0;
        hold_vld_q <= 1'b0;
      end else if (act_q && ctl_wr) begin
        hold_vld_q <= 1'b1;
        hold_q     <= ctl_data;
      end
      if (fill_go || copy_go || xfer_go) act_q <= 1'b1;
    end
  end

  assign rd_val     = (int'(rd_idx) < NREGS) ? regs_q[rd_idx] : 8'h00;
  assign addr       = addr_q;
  assign code       = code_q;
  assign pending    = pend_q;
  assign dma_active = act_q;
  assign dma_len    = ({regs_q[20], regs_q[19]} == 16'h0) ? LW'(1 << 16)
                                                          : {1'b0, regs_q[20], regs_q[19]};

  assert_one_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fill_start, copy_start, xfer_start}));
  assert_fill_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |-> $past(dat_wr));
  assert_copy_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |-> (code_q[4:0] == 5'h10) && (regs_q[23][7:6] == 2'd3));
  assert_xfer_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !regs_q[23][7]);
  assert_status_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !apply |=> !pend_q);
  assert_addr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dacc && !apply |=> addr_q == $past(addr_q) + {8'b0, $past(regs_q[15])});
  assert_parked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && ctl_wr && !dma_done |=> $stable(code_q) && $stable(hi_q));

  for (genvar g = LOCK_FROM; g < NREGS; g++) begin : g_lock
    assert_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      apply && is_regw && (widx == 5'(g)) && !regs_q[1][2] |=> $stable(regs_q[g]));
  end

endmodule

// File: tb/ctrl_port_decoder_bench.sv
module ctrl_port_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, dat_wr = 0, dat_rd = 0, stat_rd = 0, dma_done = 0;
  logic [15:0] ctl_data = '0;
  logic [4:0]  rd_idx = '0;
  logic [7:0]  rd_val;
  logic [15:0] addr;
  logic [5:0]  code;
  logic        pending, fill_start, copy_start, xfer_start, dma_active;
  logic [16:0] dma_len;

  int checks = 0, fails = 0;

  ctrl_port_decoder u_ctrl_port_decoder (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .stat_rd(stat_rd), .dma_done(dma_done),
    .rd_idx(rd_idx), .rd_val(rd_val), .addr(addr), .code(code), .pending(pending),
    .fill_start(fill_start), .copy_start(copy_start), .xfer_start(xfer_start),
    .dma_len(dma_len), .dma_active(dma_active));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  m_regs [32];
  logic [15:0] m_addr, m_hold;
  logic [5:0]  m_code;
  logic [1:0]  m_hi;
  logic        m_pend, m_arm, m_act, m_hv, m_fs, m_cs, m_xs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_regs[i]) m_regs[i] = 8'h00;
      m_addr = 0; m_hold = 0; m_code = 0; m_hi = 0;
      m_pend = 0; m_arm = 0; m_act = 0; m_hv = 0; m_fs = 0; m_cs = 0; m_xs = 0;
    end else begin
      automatic bit go = 0;
      automatic logic [15:0] w = ctl_data;
      automatic bit was_act = m_act;
      m_fs = 0; m_cs = 0; m_xs = 0;
      if (was_act) begin
        if (dma_done && m_hv) begin go = 1; w = m_hold; end
        else if (dma_done && ctl_wr) go = 1;
      end else go = ctl_wr;
      if (go) begin
        if (!m_pend) begin
          if (w[15:14] == 2'b10) begin
            automatic int idx = int'(w[12:8]);
            if (idx < 24 && (idx < 11 || m_regs[1][2])) m_regs[idx] = w[7:0];
          end else m_pend = 1;
          m_addr = {m_hi, w[13:0]};
          m_code[1:0] = w[15:14];
        end else begin
          m_pend = 0;
          m_hi = w[1:0];
          m_addr[15:14] = w[1:0];
          m_code[5:2] = w[7:4];
          if (m_code[5] && m_regs[1][4]) begin
            case (m_regs[23][7:6])
              2'd2: if (m_code[3:0] == 4'h1) m_arm = 1;
              2'd3: if (m_code[4:0] == 5'h10) m_cs = 1;
              default: m_xs = 1;
            endcase
          end
        end
      end else begin
        if (dat_wr || dat_rd) begin
          m_pend = 0;
          m_addr = m_addr + 16'(m_regs[15]);
          if (dat_wr && m_arm) begin m_fs = 1; m_arm = 0; end
        end
        if (stat_rd) m_pend = 0;
      end
      if (was_act && dma_done) begin m_act = 0; m_hv = 0; end
      else if (was_act && ctl_wr) begin m_hv = 1; m_hold = ctl_data; end
      if (m_fs || m_cs || m_xs) m_act = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      automatic int exp_len = ({m_regs[20], m_regs[19]} == 16'h0) ? 65536 : int'({m_regs[20], m_regs[19]});
      chk("R3 R4 R11 addr", addr, m_addr);
      chk("R3 R4 code", code, m_code);
      chk("R3 R4 R10 pending", pending, m_pend);
      chk("R5 fill_start", fill_start, m_fs);
      chk("R6 copy_start", copy_start, m_cs);
      chk("R7 xfer_start", xfer_start, m_xs);
      chk("R8 dma_len", dma_len, exp_len);
      chk("R12 dma_active", dma_active, m_act);
      chk("R2 R9 rd_val", rd_val, m_regs[rd_idx]);
    end
  end

  task automatic cyc(input bit c, input logic [15:0] w, input bit dw, input bit dr,
                     input bit sr, input bit dd);
    ctl_wr = c; ctl_data = w; dat_wr = dw; dat_rd = dr; stat_rd = sr; dma_done = dd;
    @(negedge clk);
    ctl_wr = 0; dat_wr = 0; dat_rd = 0; stat_rd = 0; dma_done = 0;
  endtask
  task automatic wc(input logic [15:0] w); cyc(1, w, 0, 0, 0, 0); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_idx = 1;
    chk("R1 addr after reset", addr, 0);
    chk("R1 pending after reset", pending, 0);
    chk("R1 reg1 after reset", rd_val, 0);
    chk("R1 active after reset", dma_active, 0);
    rd_idx = 15;
    wc(16'h8F05); chk("R9 locked reg15", rd_val, 0);
    wc(16'h8114); wc(16'h8F02); chk("R9 unlocked reg15", rd_val, 2);
    rd_idx = 25;
    wc(16'h9955); chk("R2 index 25 no effect", rd_val, 0);
    wc(16'h4123); chk("R3 first word addr", addr, 16'h0123); chk("R3 pending set", pending, 1);
    wc(16'h0002); chk("R4 second word addr", addr, 16'h8123); chk("R4 code", code, 1);
    repeat (3) cyc(0, 0, 1, 0, 0, 0);
    chk("R11 addr step", addr, 16'h8129);
    wc(16'h0005); chk("R3 latched high bits", addr, 16'h8005);
    cyc(0, 0, 0, 0, 1, 0); chk("R10 status read clears", pending, 0);
    wc(16'h4000); cyc(0, 0, 0, 1, 0, 0); chk("R10 data read clears", pending, 0);
    wc(16'h9780); wc(16'h9303); wc(16'h9400);
    wc(16'h4000); wc(16'h0080); chk("R5 armed not started", fill_start, 0);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R5 fill start", fill_start, 1); chk("R8 length", dma_len, 3);
    chk("R12 active on fill", dma_active, 1);
    cyc(0, 0, 0, 0, 0, 1);
    wc(16'h97C0); wc(16'h0000); wc(16'h00C0); chk("R6 copy start", copy_start, 1);
    rd_idx = 15;
    wc(16'h8F04); chk("R12 parked write", rd_val, 2);
    cyc(0, 0, 0, 0, 0, 1); chk("R12 replayed write", rd_val, 4);
    wc(16'h0000); wc(16'h00D0); chk("R6 wrong code", copy_start, 0);
    chk("R6 not active", dma_active, 0);
    wc(16'h9700); wc(16'h9300); chk("R8 zero length", dma_len, 65536);
    wc(16'h4000); wc(16'h0080); chk("R7 xfer start", xfer_start, 1);
    cyc(0, 0, 0, 0, 0, 1);
    wc(16'h8104); wc(16'h4000); wc(16'h0080);
    chk("R5 disabled no start", dma_active, 0);
    for (int n = 0; n < 3000; n++) begin
      automatic int a = $urandom % 9;
      automatic logic [15:0] w;
      rd_idx = 5'($urandom);
      case ($urandom % 16)
        0: w = 16'h8114; 1: w = 16'h8F01; 2: w = 16'h8FFF; 3: w = 16'h9780;
        4: w = 16'h97C0; 5: w = 16'h9700; 6: w = 16'h9302; 7: w = 16'h9400;
        8: w = 16'h4000; 9: w = 16'h0080; 10: w = 16'h00C0; 11: w = 16'h0003;
        12: w = 16'h8104; 13: w = 16'hB3AA; default: w = 16'($urandom);
      endcase
      case (a)
        0, 1, 2: wc(w);
        3: cyc(0, 0, 1, 0, 0, 0);
        4: cyc(0, 0, 0, 1, 0, 0);
        5: cyc(0, 0, 0, 0, 1, 0);
        6: cyc(0, 0, 0, 0, 0, 1);
        default: cyc(0, 0, 0, 0, 0, 0);
      endcase
    end
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule